// File: doc/BRIEF.md
# Buffered Up/Down PWM Timer Channel

This block is a single channel of a PWM timer. It has a counter whose width is a parameter. The counter runs in one of three shapes:

- a rising sawtooth, which wraps from the period value to zero;
- a falling sawtooth, which reloads the period value after reaching zero;
- a triangle, which climbs to the period value and then descends to zero.

The counter advances only on a strobe from an external prescaler, and only while the channel is running. Start, stop and clear trigger inputs let software, a comparator or another channel's compare match control it. A clear loads a programmable phase value, so several channels can start from one shared start pulse with their waveforms offset.

Two compare registers shape one reference waveform. The first sets it and the second clears it. In triangle mode the set is recognised only on the rising slope and the clear only on the falling slope. Each compare register has a buffer behind it. The buffer contents move into the active registers at the peak, at the trough, or at both, so the two halves of a triangle period can use different thresholds. From the reference, two complementary pins are driven. After every reference edge both pins are held inactive for a programmed number of counter strobes. The channel also raises one-cycle interrupt pulses at the top and bottom turning points. A capture path can latch the counter on a rising edge of an input.

Configuration is through a plain write port:

| Address | Contents |
|---|---|
| 0 | Control: bits [1:0] shape, bits [3:2] transfer select, bit 4 capture enable |
| 1 | Period |
| 2 | Set-threshold buffer |
| 3 | Clear-threshold buffer |
| 4 | Dead time |
| 5 | Phase load value |

Top module: `pwm_chan`

## Requirements
- R1: After reset the counter reads 0 and the channel is stopped. Both interrupt pulses are low, the capture register is 0, the high pin is 0 and the low pin is 1. The period resets to all ones and the shape to rising.
- R2: With shape code 0 (rising sawtooth), each strobe adds 1, and the strobe that finds the counter equal to the period loads 0. The overflow pulse is high for exactly the cycle in which the counter shows that 0.
- R3: With shape code 1 (falling sawtooth), each strobe subtracts 1, and the strobe that finds the counter at 0 loads the period. The underflow pulse is high for exactly the cycle in which the counter shows that reloaded value.
- R4: With shape code 2 (triangle), the counter climbs to the period and turns down; it then descends to 0 and turns up. The overflow pulse accompanies the first value after the peak and the underflow pulse accompanies the first value after the trough. The direction output is 1 while climbing.
- R5: The counter changes only on an edge where the strobe is high and the channel was already running. A start trigger sets the running state and a stop trigger clears it. Stop wins when both arrive together.
- R6: A clear trigger loads the phase value into the counter and sets the direction to climbing. It forces the reference low with no dead time, and it overrides any step on that edge.
- R7: In the sawtooth shapes, a strobe that visits the set threshold drives the reference high, and a strobe that visits the clear threshold drives it low. Clear wins when the two are equal.
- R8: In the triangle shape, the set threshold acts only while climbing and the clear threshold only while descending. Thresholds from 1 to period-1 are supported.
- R9: Control bits [3:2] select the buffer transfer. With 0, writes go straight into the active thresholds as well as the buffers. Bit 2 copies both buffers into the active thresholds at the peak, or at the wrap in the rising sawtooth. Bit 3 copies them at the trough, or at the wrap in the falling sawtooth.
- R10: After every reference edge, both pins stay low until the dead time count of strobes has passed. After that, the high pin follows the reference and the low pin its inverse. With dead time 0 the pins switch on the same edge as the reference.
- R11: A reference pulse shorter than the dead time never activates its pin, because each edge restarts the dead-time count.
- R12: With capture enabled (control bit 4), a rising edge on the capture input copies the counter value seen at that clock edge into the capture register. With capture disabled, or while the input stays high, the capture register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counter strobe from the prescaler |
| start_trig | input | 1 | Start trigger |
| stop_trig | input | 1 | Stop trigger |
| clear_trig | input | 1 | Clear trigger, loads the phase value |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | W | Register write data |
| cap_in | input | 1 | Capture input |
| cnt_q | output | W | Counter value |
| cnt_up | output | 1 | 1 while counting upward |
| ovf_irq | output | 1 | Top turning point pulse |
| udf_irq | output | 1 | Bottom turning point pulse |
| out_hi | output | 1 | Dead-time-gated reference |
| out_lo | output | 1 | Dead-time-gated inverse reference |
| cap_q | output | W | Captured counter value |

## Verification
Every result appears one clock after its cause. A strobe becomes visible on the counter, the turning-point pulses, the reference-driven pins and the capture register one clock after the edge that saw it. A write or trigger applies at the edge it is held across. The pins wake exactly the dead-time count of strobes after a reference edge. The bench drives every input just after a falling edge, samples just before driving the next one, and derives the expected counter value from the number of strobes elapsed by modular arithmetic. It sweeps all threshold pairs of a small period in both the rising and the triangle shapes, as well as several dead times, three transfer selections and phase offsets.

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int W  = 16,
  parameter int DW = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         start_trig,
  input  logic         stop_trig,
  input  logic         clear_trig,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         cap_in,
  output logic [W-1:0] cnt_q,
  output logic         cnt_up,
  output logic         ovf_irq,
  output logic         udf_irq,
  output logic         out_hi,
  output logic         out_lo,
  output logic [W-1:0] cap_q
);
  localparam logic [1:0] M_DN  = 2'd1;
  localparam logic [1:0] M_TRI = 2'd2;
  localparam logic [2:0] A_CTRL = 3'd0, A_PER = 3'd1, A_BUFA = 3'd2,
                         A_BUFB = 3'd3, A_DT = 3'd4, A_PH = 3'd5;

  logic [1:0]    mode, xfer;
  logic          cap_en;
  logic [W-1:0]  period, phase, buf_a, buf_b, cmp_a, cmp_b;
  logic [DW-1:0] dt_cfg, dtc;
  logic          run, dir_q, ref_q, ref_next, cap_prev;

  wire tri_m    = (mode == M_TRI);
  assign cnt_up = tri_m ? dir_q : (mode != M_DN);
  wire step     = cnt_en & run & ~clear_trig;
  wire at_top   = (cnt_q == period);
  wire at_bot   = (cnt_q == '0);
  wire top_evt  = step & cnt_up & at_top;
  wire bot_evt  = step & ~cnt_up & at_bot;
  wire xfer_now = (top_evt & xfer[0]) | (bot_evt & xfer[1]);
  wire direct   = (xfer == 2'b00);
  wire a_hit    = step & (cnt_q == cmp_a) & (~tri_m | cnt_up);
  wire b_hit    = step & (cnt_q == cmp_b) & (~tri_m | ~cnt_up);
  wire wr_a     = wr_en & (wr_addr == A_BUFA);
  wire wr_b     = wr_en & (wr_addr == A_BUFB);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= '0; xfer <= '0; cap_en <= 1'b0;
      period <= '1; phase <= '0; dt_cfg <= '0;
      buf_a <= '0; buf_b <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin mode <= wr_data[1:0]; xfer <= wr_data[3:2]; cap_en <= wr_data[4]; end
        A_PER:  period <= wr_data;
        A_BUFA: buf_a <= wr_data;
        A_BUFB: buf_b <= wr_data;
        A_DT:   dt_cfg <= wr_data[DW-1:0];
        A_PH:   phase <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_a <= '0; cmp_b <= '0;
    end else begin
      if (wr_a && direct) cmp_a <= wr_data;
      else if (xfer_now)  cmp_a <= buf_a;
      if (wr_b && direct) cmp_b <= wr_data;
      else if (xfer_now)  cmp_b <= buf_b;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          run <= 1'b0;
    else if (stop_trig)  run <= 1'b0;
    else if (start_trig) run <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0; dir_q <= 1'b1;
    end else if (clear_trig) begin
      cnt_q <= phase; dir_q <= 1'b1;
    end else if (step) begin
      if (tri_m) begin
        if (top_evt)      begin cnt_q <= cnt_q - 1'b1; dir_q <= 1'b0; end
        else if (bot_evt) begin cnt_q <= cnt_q + 1'b1; dir_q <= 1'b1; end
        else cnt_q <= dir_q ? cnt_q + 1'b1 : cnt_q - 1'b1;
      end else if (mode == M_DN) begin
        cnt_q <= bot_evt ? period : cnt_q - 1'b1;
      end else begin
        cnt_q <= top_evt ? '0 : cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_irq <= 1'b0; udf_irq <= 1'b0;
    end else begin
      ovf_irq <= top_evt; udf_irq <= bot_evt;
    end
  end

  always_comb begin
    ref_next = ref_q;
    if (clear_trig || b_hit) ref_next = 1'b0;
    else if (a_hit)          ref_next = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q <= 1'b0; dtc <= '0;
    end else begin
      ref_q <= ref_next;
      if (clear_trig)                 dtc <= '0;
      else if (ref_next != ref_q)     dtc <= dt_cfg;
      else if (cnt_en && dtc != '0)   dtc <= dtc - 1'b1;
    end
  end

  assign out_hi = ref_q & (dtc == '0);
  assign out_lo = ~ref_q & (dtc == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_prev <= 1'b0; cap_q <= '0;
    end else begin
      cap_prev <= cap_in;
      if (cap_en && cap_in && !cap_prev) cap_q <= cnt_q;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !clear_trig) |=> $stable(cnt_q)); // R5
  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clear_trig) |=> $stable(cnt_q)); // R5
  AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !tri_m && mode != M_DN && at_top) |=> (cnt_q == '0 && ovf_irq)); // R2
  AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode == M_DN && at_bot) |=> (cnt_q == $past(period) && udf_irq)); // R3
  AST_TRI_PEAK: assert property (@(posedge clk) disable iff (!rst_n)
    (step && tri_m && cnt_up && at_top) |=> (!cnt_up && ovf_irq)); // R4
  AST_CLEAR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    clear_trig |=> (cnt_q == $past(phase) && !out_hi && out_lo)); // R6
  AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_trig && ref_next != ref_q && dt_cfg != '0) |=> (!out_hi && !out_lo)); // R10
  AST_CAP_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && cap_in && !cap_prev) |=> (cap_q == $past(cnt_q))); // R12
endmodule

// File: tb/tb_pwm_chan.sv
module tb_pwm_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b1, start_trig = 1'b0, stop_trig = 1'b0, clear_trig = 1'b0;
  logic        wr_en = 1'b0, cap_in = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] cnt_q, cap_q;
  logic        cnt_up, ovf_irq, udf_irq, out_hi, out_lo;
  int errs = 0, checks = 0;

  always #2 clk = ~clk;

  pwm_chan #(.W(16), .DW(8)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .start_trig(start_trig),
    .stop_trig(stop_trig), .clear_trig(clear_trig), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .cap_in(cap_in), .cnt_q(cnt_q),
    .cnt_up(cnt_up), .ovf_irq(ovf_irq), .udf_irq(udf_irq), .out_hi(out_hi),
    .out_lo(out_lo), .cap_q(cap_q));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic trig(input int which);
    if (which == 0) start_trig = 1'b1;
    if (which == 1) stop_trig = 1'b1;
    if (which == 2) clear_trig = 1'b1;
    @(negedge clk);
    start_trig = 1'b0; stop_trig = 1'b0; clear_trig = 1'b0;
  endtask

  task automatic sweep(input int mode, input int xf, input int P, input int A,
                       input int B, input int D, input int ph, input int n,
                       input bit chk_out, input int tw, input int B2,
                       input string ctag, input string otag);
    int prev_ref = 0, since = 1000;
    trig(1);
    wr(0, mode); wr(1, P); wr(2, A); wr(3, B); wr(4, D); wr(5, ph);
    if (xf != 0) wr(0, (xf << 2) | mode);
    trig(2);
    trig(0);
    for (int t = 0; t < n; t++) begin
      int m, c, s, k, beff, rf, ov, ud;
      m = P + 1; s = 0; k = 0; rf = 0; ov = 0; ud = 0;
      if (mode == 0) begin
        c = (ph + t) % m; ov = (t > 0 && c == 0); rf = (c > A && c <= B);
      end else if (mode == 1) begin
        c = ((ph - t) % m + m) % m; ud = (t > 0 && c == P);
      end else begin
        s = t % (2 * P); k = t / (2 * P);
        c = (s <= P) ? s : 2 * P - s;
        ov = (t > 0 && s == P + 1); ud = (t > 1 && s == 1);
        beff = B;
        if (tw >= 0 && (xf & 1)) beff = B2;
        else if (tw >= 0 && xf == 2 && k >= 1) beff = B2;
        rf = (s > A && s <= 2 * P - beff);
      end
      if (t > 0) begin
        if (rf != prev_ref) since = 0; else since++;
      end
      chk(ctag, cnt_q, c);
      chk(ctag, ovf_irq, ov);
      chk(ctag, udf_irq, ud);
      if (chk_out) begin
        chk(otag, out_hi, (rf == 1 && since >= D));
        chk(otag, out_lo, (rf == 0 && since >= D));
      end
      prev_ref = rf;
      if (t == tw) begin wr_en = 1'b1; wr_addr = 3'd3; wr_data = 16'(B2); end
      else wr_en = 1'b0;
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  task automatic run_all();
    int v, e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cnt", cnt_q, 0);
    chk("R1 ovf", ovf_irq, 0);
    chk("R1 udf", udf_irq, 0);
    chk("R1 hi", out_hi, 0);
    chk("R1 lo", out_lo, 1);
    chk("R1 cap", cap_q, 0);
    chk("R1 dir", cnt_up, 1);
    @(negedge clk);
    chk("R1 stopped", cnt_q, 0);

    for (int a = 0; a <= 4; a++)
      for (int b = a + 1; b <= 5; b++)
        sweep(0, 0, 5, a, b, 0, 0, 18, 1, -1, 0, "R2", "R7");
    sweep(1, 0, 6, 1, 3, 0, 3, 20, 0, -1, 0, "R3", "R3");
    sweep(1, 0, 6, 1, 3, 0, 6, 20, 0, -1, 0, "R3", "R3");
    sweep(0, 0, 6, 1, 3, 0, 4, 20, 0, -1, 0, "R6", "R6");
    for (int a = 1; a <= 3; a++)
      for (int b = 1; b <= 3; b++)
        sweep(2, 0, 4, a, b, 0, 0, 24, 1, -1, 0, "R4", "R8");
    for (int d = 0; d <= 4; d++)
      sweep(0, 0, 9, 1, 6, d, 0, 30, 1, -1, 0, "R2", "R10");
    for (int d = 1; d <= 3; d++)
      sweep(2, 0, 6, 2, 3, d, 0, 36, 1, -1, 0, "R4", "R10");
    sweep(0, 0, 7, 2, 3, 3, 0, 24, 1, -1, 0, "R2", "R11");
    sweep(0, 0, 7, 2, 4, 2, 0, 24, 1, -1, 0, "R2", "R11");
    sweep(2, 1, 6, 2, 2, 0, 0, 36, 1, 2, 4, "R4", "R9");
    sweep(2, 2, 6, 2, 2, 0, 0, 36, 1, 2, 4, "R4", "R9");
    sweep(2, 3, 6, 2, 2, 0, 0, 36, 1, 2, 4, "R4", "R9");

    // R5: strobe gating, stop, stop-over-start
    trig(1); wr(0, 0); wr(1, 1000); wr(5, 0); trig(2); trig(0);
    e = 0;
    for (int i = 0; i < 10; i++) begin
      cnt_en = (i % 2 == 0);
      @(negedge clk);
      e += (i % 2 == 0);
      chk("R5 strobe", cnt_q, e);
    end
    cnt_en = 1'b1;
    trig(1);
    v = cnt_q;
    chk("R5 last step", v, e + 1);
    repeat (4) @(negedge clk);
    chk("R5 stopped", cnt_q, v);
    start_trig = 1'b1; stop_trig = 1'b1;
    @(negedge clk);
    start_trig = 1'b0; stop_trig = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 stop wins", cnt_q, v);
    trig(0);
    chk("R5 start edge", cnt_q, v);
    @(negedge clk);
    chk("R5 resumed", cnt_q, v + 1);

    // R6: clear mid-run loads phase
    wr(5, 40);
    trig(2);
    chk("R6 phase load", cnt_q, 40);
    @(negedge clk);
    chk("R6 continue", cnt_q, 41);

    // R12: capture
    wr(0, 16);
    v = cnt_q; cap_in = 1'b1;
    @(negedge clk);
    chk("R12 capture", cap_q, v);
    repeat (3) @(negedge clk);
    chk("R12 held high", cap_q, v);
    cap_in = 1'b0;
    @(negedge clk);
    e = cnt_q; cap_in = 1'b1;
    @(negedge clk);
    chk("R12 second edge", cap_q, e);
    cap_in = 1'b0; wr(0, 0);
    cap_in = 1'b1;
    @(negedge clk);
    chk("R12 disabled", cap_q, e);
    cap_in = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        checks++; errs++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule